// File: doc/BRIEF.md
# Second-Order Delta-Sigma Bitstream Modulator

This block turns a stream of 16-bit audio samples into a single-bit pulse-density stream running 256 times faster than the sample rate. Each clock of the block is one modulator step; a sample, once captured, is held unchanged until the next one arrives (zero-order hold). A two-stage integrator loop with saturating accumulators shapes the quantisation noise out of the audio band. The bitstream and its inverse leave the block as a differential pair for an external reconstruction filter.

Samples may be coded either as offset binary or as two's complement, selected per sample by a format input. Internally both are reduced to one signed level by flipping the top bit of offset-binary codes. A feeder writes a new sample with a one-cycle strobe. The block raises a one-cycle request every 256 running clocks so the feeder can keep pace. While the enable input is low, the loop is parked: the integrators are cleared, the held sample returns to midpoint, and the output toggles every clock.

Two control states exist. ST_IDLE is the parked state. ST_RUN is the modulating state. The transitions are as follows. ST_IDLE goes to ST_RUN on the first clock edge that sees enable high. ST_RUN goes back to ST_IDLE on the first edge that sees enable low. Each state otherwise holds.

Top module: `dsm2_modulator`

## Requirements
- R1: While reset is asserted, bit_p is 0, bit_n is 1 and sample_req is 0.
- R2: bit_n is always the inverse of bit_p.
- R3: In ST_IDLE, bit_p inverts on every clock edge, the integrators read zero and sample_req stays 0. A clock edge that sees enable low moves the block to ST_IDLE after that edge.
- R4: With fmt_signed = 0 (offset binary), the code maps to the signed level code − 32768: 0xFFFF is the top level, 0x8000 is midpoint, 0x7FFF is one step below midpoint and 0x0000 is the bottom level.
- R5: With fmt_signed = 1 (two's complement), the code itself is the signed level: 0x7FFF is the top level, 0x0000 is midpoint, 0xFFFF is one step below midpoint and 0x8000 is the bottom level.
- R6: On each ST_RUN edge, let f be +32768 when bit_p = 1 and −32768 otherwise. Then A' = sat(A + x − f), B' = sat(B + A' − 2f), and the new bit_p is 1 exactly when B' ≥ 0. Here sat clamps to the range [−524288, 524287] of a 20-bit signed value.
- R7: The held level x changes only on an ST_RUN edge with sample_strobe high, and it takes the converted sample_in. On every ST_IDLE edge it resets to 0 (midpoint), and strobes in ST_IDLE are ignored.
- R8: sample_req is a one-cycle pulse. It is high during the 256th cycle spent in ST_RUN and during every 256th cycle after that.
- R9: A midpoint level gives ones on bit_p at a density of one half, within 16 over 1024 clocks.
- R10: A full-scale positive level gives at least 90% ones on bit_p, and a full-scale negative level gives at most 10% ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock, 256 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the loop when high, park it when low |
| fmt_signed | input | 1 | Sample coding: 1 two's complement, 0 offset binary |
| sample_strobe | input | 1 | One-cycle write of sample_in |
| sample_in | input | 16 | Audio sample code |
| sample_req | output | 1 | One-cycle request for the next sample |
| bit_p | output | 1 | Pulse-density bitstream |
| bit_n | output | 1 | Inverse of bit_p |

## Verification
The loop is driven with a held midpoint and with quarter and three-quarter levels in both codings. These patterns separate a correct top-bit conversion from a swapped or missing one, because the ones density moves to the wrong side of one half. Full-scale extremes held for long windows show that feedback polarity and the clamp keep the stream near all ones or all zeros. Rapid alternation between the extremes every few clocks forces the integrators into their clamps, where a missing or misplaced limit diverges from the step-by-step reference. A strobe written while parked, followed by a resume, shows that the stale sample is dropped and the held level restarts at midpoint.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    // Control states of the modulator sequencer.
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } dsm_state_e;

endpackage

// File: rtl/dsm_fmt_conv.sv
// Reduces either sample coding to one signed level.
// Offset binary differs from two's complement only in its top bit.
module dsm_fmt_conv #(
    parameter int SAMPLE_W = 16
) (
    input  logic [SAMPLE_W-1:0]        code,
    input  logic                       twos,
    output logic signed [SAMPLE_W-1:0] level
);

    localparam logic [SAMPLE_W-1:0] TOP_BIT = {1'b1, {(SAMPLE_W-1){1'b0}}};

    always_comb begin
        if (twos) begin
            level = code;
        end else begin
            level = code ^ TOP_BIT;
        end
    end

endmodule

// File: rtl/dsm_sat_integ.sv
// One integrator stage with a clamped accumulator.
// acc_d is the value the stage takes at the next running edge.
module dsm_sat_integ #(
    parameter int W    = 20,
    parameter int OP_W = 18
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic signed [OP_W-1:0] op,
    output logic signed [W-1:0]    acc_d
);

    localparam int SUM_W = ((W > OP_W) ? W : OP_W) + 1;
    localparam logic signed [SUM_W-1:0] HI = SUM_W'((64'sd1 <<< (W - 1)) - 64'sd1);
    localparam logic signed [SUM_W-1:0] LO = ~HI;

    logic signed [W-1:0]     acc_q;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'(acc_q) + SUM_W'(op);
        if (sum > HI) begin
            acc_d = HI[W-1:0];
        end else if (sum < LO) begin
            acc_d = LO[W-1:0];
        end else begin
            acc_d = sum[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (!run) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/dsm_seq.sv
// Sequencer: the run/park state machine and the oversampling phase counter.
module dsm_seq
    import dsm_pkg::*;
#(
    parameter int OSR_LOG2 = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic run,
    output logic sample_req
);

    dsm_state_e            state_q;
    dsm_state_e            state_d;
    logic [OSR_LOG2-1:0]   phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        run     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                run = 1'b0;
                if (enable) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                run = 1'b1;
                if (!enable) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign sample_req = run & (&phase_q);

endmodule

// File: rtl/dsm2_modulator.sv
// Two-stage delta-sigma loop with zero-order-held input and a 1-bit quantiser.
module dsm2_modulator #(
    parameter int SAMPLE_W = 16,
    parameter int INT_W    = 20,
    parameter int OSR_LOG2 = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                fmt_signed,
    input  logic                sample_strobe,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                sample_req,
    output logic                bit_p,
    output logic                bit_n
);

    localparam int FB_W  = SAMPLE_W + 2;
    localparam int OP2_W = INT_W + 2;

    logic                       run;
    logic                       q;
    logic signed [SAMPLE_W-1:0] level;
    logic signed [SAMPLE_W-1:0] held_x;
    logic signed [FB_W-1:0]     fb;
    logic signed [FB_W-1:0]     op1;
    logic signed [OP2_W-1:0]    fb2;
    logic signed [OP2_W-1:0]    op2;
    logic signed [INT_W-1:0]    i1_d;
    logic signed [INT_W-1:0]    i2_d;

    dsm_seq #(
        .OSR_LOG2 (OSR_LOG2)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .run        (run),
        .sample_req (sample_req)
    );

    dsm_fmt_conv #(
        .SAMPLE_W (SAMPLE_W)
    ) u_conv (
        .code  (sample_in),
        .twos  (fmt_signed),
        .level (level)
    );

    // Zero-order hold of the current level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_x <= '0;
        end else if (!run) begin
            held_x <= '0;
        end else if (sample_strobe) begin
            held_x <= level;
        end
    end

    // Feedback is plus or minus full scale, by the last output bit.
    always_comb begin
        fb  = {(q ? 2'b00 : 2'b11), 1'b1, {(SAMPLE_W-1){1'b0}}};
        op1 = FB_W'(held_x) - fb;
        fb2 = OP2_W'(fb) <<< 1;
        op2 = OP2_W'(i1_d) - fb2;
    end

    dsm_sat_integ #(
        .W    (INT_W),
        .OP_W (FB_W)
    ) u_int1 (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .op    (op1),
        .acc_d (i1_d)
    );

    dsm_sat_integ #(
        .W    (INT_W),
        .OP_W (OP2_W)
    ) u_int2 (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .op    (op2),
        .acc_d (i2_d)
    );

    // Quantiser: the sign of the second stage, or a plain toggle while parked.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (!run) begin
            q <= ~q;
        end else begin
            q <= ~i2_d[INT_W-1];
        end
    end

    assign bit_p = q;
    assign bit_n = ~q;

endmodule

// File: rtl/dsm2_checker.sv
module dsm2_checker #(
    parameter int SAMPLE_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       run,
    input logic                       sample_strobe,
    input logic                       sample_req,
    input logic                       bit_p,
    input logic                       bit_n,
    input logic signed [SAMPLE_W-1:0] held
);

    assert_pair_inverse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_n == ~bit_p);

    assert_idle_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (bit_p != $past(bit_p)));

    assert_idle_no_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !sample_req);

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sample_strobe) |=> $stable(held));

    assert_idle_midpoint_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (held == '0));

    assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req |=> !sample_req);

endmodule

bind dsm2_modulator dsm2_checker #(
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .sample_strobe (sample_strobe),
    .sample_req    (sample_req),
    .bit_p         (bit_p),
    .bit_n         (bit_n),
    .held          (held_x)
);

// File: tb/sim_dsm2_modulator.sv
module sim_dsm2_modulator;

    localparam int CLK_PERIOD = 10;
    localparam int SAT_HI     = 524287;
    localparam int SAT_LO     = -524288;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        fmt_signed = 1'b0;
    logic        sample_strobe = 1'b0;
    logic [15:0] sample_in = 16'h0000;
    logic        sample_req;
    logic        bit_p;
    logic        bit_n;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // Behavioural reference state.
    int m_run = 0;
    int m_q   = 0;
    int m_a   = 0;
    int m_b   = 0;
    int m_x   = 0;
    int m_ph  = 0;

    dsm2_modulator u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .fmt_signed    (fmt_signed),
        .sample_strobe (sample_strobe),
        .sample_in     (sample_in),
        .sample_req    (sample_req),
        .bit_p         (bit_p),
        .bit_n         (bit_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int clampv(input int v);
        if (v > SAT_HI) return SAT_HI;
        if (v < SAT_LO) return SAT_LO;
        return v;
    endfunction

    function automatic int to_level(input logic [15:0] c, input logic s);
        if (s) return c[15] ? int'(c) - 65536 : int'(c);
        return int'(c) - 32768;
    endfunction

    task automatic cmp(input string t, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", t, $time, act, exp);
        end
    endtask

    task automatic cmp_range(input string t, input int act, input int lo, input int hi);
        n_cmp++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d..%0d", t, $time, act, lo, hi);
        end
    endtask

    // Reference step on every rising edge, then comparison a quarter period later.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_q = 0; m_a = 0; m_b = 0; m_x = 0; m_ph = 0;
        end else begin
            if (m_run == 0) begin
                m_a = 0; m_b = 0; m_x = 0; m_ph = 0;
                m_q = 1 - m_q;
            end else begin
                int f;
                f   = (m_q != 0) ? 32768 : -32768;
                m_a = clampv(m_a + m_x - f);
                m_b = clampv(m_b + m_a - 2 * f);
                m_q = (m_b >= 0) ? 1 : 0;
                if (sample_strobe) m_x = to_level(sample_in, fmt_signed);
                m_ph = (m_ph + 1) % 256;
            end
            m_run = enable ? 1 : 0;
        end
        #(CLK_PERIOD/4);
        if (!done) begin
            cmp({tag, " bit_p vs loop model (R6)"}, int'(bit_p), m_q);
            cmp("R2 bit_n inverse", int'(bit_n), 1 - m_q);
            cmp("R8 sample_req timing", int'(sample_req), (m_run != 0 && m_ph == 255) ? 1 : 0);
        end
    end

    task automatic strobe(input logic [15:0] v, input logic s);
        @(negedge clk);
        sample_in = v;
        fmt_signed = s;
        sample_strobe = 1'b1;
        @(negedge clk);
        sample_strobe = 1'b0;
    endtask

    task automatic count_window(input int n, output int ones, output int reqs);
        ones = 0;
        reqs = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ones += int'(bit_p);
            reqs += int'(sample_req);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int ones;
        int reqs;
        int p0;
        // R1: reset values
        #(CLK_PERIOD/4);
        cmp("R1 bit_p in reset", int'(bit_p), 0);
        cmp("R1 bit_n in reset", int'(bit_n), 1);
        cmp("R1 sample_req in reset", int'(sample_req), 0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R3: parked toggling
        tag = "R3";
        repeat (20) @(negedge clk);
        p0 = int'(bit_p);
        @(negedge clk);
        cmp("R3 idle toggle", int'(bit_p), 1 - p0);
        count_window(64, ones, reqs);
        cmp("R3 idle density", ones, 32);
        cmp("R3 idle no request", reqs, 0);

        // R7: strobe while parked is dropped
        tag = "R7";
        strobe(16'hFFFF, 1'b0);
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        count_window(1024, ones, reqs);
        cmp_range("R7 stale strobe ignored, midpoint density", ones, 496, 528);
        count_window(1024, ones, reqs);
        cmp_range("R9 midpoint density", ones, 496, 528);
        cmp("R8 requests per 1024 running clocks", reqs, 4);

        // R4: offset binary coding
        tag = "R4";
        strobe(16'h8000, 1'b0);
        count_window(1024, ones, reqs);
        cmp_range("R4 0x8000 unsigned midpoint", ones, 496, 528);
        strobe(16'hC000, 1'b0);
        count_window(1024, ones, reqs);
        cmp_range("R4 0xC000 unsigned three quarters", ones, 720, 816);
        strobe(16'h4000, 1'b0);
        count_window(1024, ones, reqs);
        cmp_range("R4 0x4000 unsigned one quarter", ones, 208, 304);
        strobe(16'hFFFF, 1'b0);
        count_window(1024, ones, reqs);
        cmp_range("R10 0xFFFF unsigned full positive", ones, 922, 1024);
        strobe(16'h0000, 1'b0);
        count_window(1024, ones, reqs);
        cmp_range("R10 0x0000 unsigned full negative", ones, 0, 102);

        // R5: two's complement coding
        tag = "R5";
        strobe(16'h0000, 1'b1);
        count_window(1024, ones, reqs);
        cmp_range("R5 0x0000 signed midpoint", ones, 496, 528);
        strobe(16'hC000, 1'b1);
        count_window(1024, ones, reqs);
        cmp_range("R5 0xC000 signed one quarter", ones, 208, 304);
        strobe(16'h7FFF, 1'b1);
        count_window(1024, ones, reqs);
        cmp_range("R10 0x7FFF signed full positive", ones, 922, 1024);
        strobe(16'h8000, 1'b1);
        count_window(1024, ones, reqs);
        cmp_range("R10 0x8000 signed full negative", ones, 0, 102);

        // R6: clamp stress with rapid full-scale swings
        tag = "R6";
        for (int k = 0; k < 200; k++) begin
            strobe((k % 2 == 0) ? 16'h7FFF : 16'h8000, 1'b1);
            @(negedge clk);
        end
        for (int k = 0; k < 40; k++) begin
            strobe(16'h7FFF, 1'b1);
            repeat (40) @(negedge clk);
            strobe(16'h8000, 1'b1);
            repeat (40) @(negedge clk);
        end

        // R3 and R7: park mid-run, then resume at midpoint
        tag = "R3";
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        p0 = int'(bit_p);
        @(negedge clk);
        cmp("R3 toggle after disable", int'(bit_p), 1 - p0);
        repeat (30) @(negedge clk);
        tag = "R7";
        enable = 1'b1;
        @(negedge clk);
        count_window(1024, ones, reqs);
        cmp_range("R7 resume from midpoint", ones, 496, 528);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule